// File: doc/BRIEF.md
# Live-Register Save Unit

This block holds a general-purpose register file together with a hidden liveness mask that has one bit per register. Every accepted register write marks its register as live. An access issued with the release flag, on either the write or the read port, marks the register as dead, because that access is its last use. Software never reads or writes the mask. It only sees its effect: a call saves exactly the registers that are live at that moment.

A call command starts a save sequence. The sequencer pushes each live register to a synchronous stack memory, lowest index first, one word per cycle. It then pushes the mask word and clears the mask, since the saved values now sit on the stack. A return command runs the same steps backwards. It pops the mask word, pops the marked registers from highest index to lowest, writes them back into the register file and reinstates the popped mask. While a sequence runs, `busy` is high and the unit accepts no new command.

Top module: `liveset_save_unit`

## Requirements
- R1: After reset, `busy`, `stk_we` and `stk_re` are low and the mask is empty, so a first call pushes a single word of value 0.
- R2: An accepted write (`wr_en`=1, `wr_rel`=0) stores `wr_data` in register `wr_idx`, which `rd_data` then shows for `rd_idx`=`wr_idx`, and marks that register live.
- R3: An accepted write with `wr_rel`=1 stores its data but marks the register dead. An accepted read with `rd_en`=1 and `rd_rel`=1 marks register `rd_idx` dead. `rd_data` always shows register `rd_idx` combinationally.
- R4: If, in one cycle, a normal write marks register k live and a read with release marks the same register dead, the register stays live.
- R5: A call pushes the live registers in ascending index order, one per cycle, and then the mask word (bit i = register i, upper bits zero). Each push writes at the current stack pointer, which then decrements. The pointer resets to 2**AW-1.
- R6: When a save completes, the mask is empty. Registers written after that point belong only to later calls.
- R7: A call with an empty mask pushes just the mask word, so every return has a frame to pop.
- R8: A return reads the mask word at pointer+1, then the marked registers in descending index order, each at pointer+1 with the pointer incrementing. It writes the values back and makes the popped mask current.
- R9: `busy` is high from the cycle after an accepted call or return until the sequence ends. Calls, returns and register commands are ignored while `busy` is high. Register commands in the same cycle as a call or return are also ignored, and call wins over return.
- R10: Stack read data is taken from `stk_rdata` one cycle after `stk_re`, and only one stack operation is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_rel | input | 1 | Release flag on the write |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request (qualifies release) |
| rd_rel | input | 1 | Release flag on the read |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Read data, combinational |
| call | input | 1 | Start a save sequence |
| ret | input | 1 | Start a restore sequence |
| busy | output | 1 | Sequence in progress |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack word address |
| stk_wdata | output | 32 | Stack write data |
| stk_rdata | input | 32 | Stack read data, one cycle after `stk_re` |

## Verification
A wrong liveness bit never shows at `rd_data`. It shows only at the next call, as a push count off by one and a wrong mask word on `stk_wdata`. A wrong restore shows only after the matching return, as a clobbered value on `rd_data`. For that reason the bench follows each save with a return several frames later and compares push counts, push order, pushed words and restored register values. A pointer or ordering fault breaks the address sequence on the first push, and a missed mask clear produces extra pushes on the very next call.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_REG,
        ST_PUSH_MASK,
        ST_POP_MASK_REQ,
        ST_POP_MASK_CAP,
        ST_POP_REG_REQ,
        ST_POP_REG_WR
    } seq_state_e;

endpackage

// File: rtl/lsu_pick.sv
`timescale 1ns/1ps
module lsu_pick #(
    parameter int N          = 16,
    parameter bit HIGH_FIRST = 1'b0,
    localparam int IW        = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (vec[i]) idx = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (vec[i]) idx = IW'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lsu_regfile.sv
`timescale 1ns/1ps
module lsu_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

endmodule

// File: rtl/lsu_livemask.sv
`timescale 1ns/1ps
module lsu_livemask #(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_a_en,
    input  logic [IW-1:0]   clr_a_idx,
    input  logic            clr_b_en,
    input  logic [IW-1:0]   clr_b_idx,
    input  logic            load_en,
    input  logic [NREG-1:0] load_val,
    output logic [NREG-1:0] mask
);

    localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

    logic [NREG-1:0] mask_q, mask_d;
    logic [NREG-1:0] set_v, clr_v;

    always_comb begin
        set_v = set_en ? (ONE << set_idx) : '0;
        clr_v = '0;
        if (clr_a_en) clr_v = clr_v | (ONE << clr_a_idx);
        if (clr_b_en) clr_v = clr_v | (ONE << clr_b_idx);
        if (load_en) mask_d = load_val;
        else         mask_d = (mask_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

endmodule

// File: rtl/lsu_seq.sv
`timescale 1ns/1ps
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 8,
    localparam int IW  = $clog2(NREG),
    localparam logic [AW-1:0] SP_INIT = {AW{1'b1}}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [DW-1:0]   rf_rdata,
    output logic [IW-1:0]   rf_ridx,
    output logic            rf_we,
    output logic [IW-1:0]   rf_widx,
    output logic [DW-1:0]   rf_wdata,
    output logic            mask_load,
    output logic [NREG-1:0] mask_val,
    output logic            busy,
    output logic            stk_we,
    output logic            stk_re,
    output logic [AW-1:0]   stk_addr,
    output logic [DW-1:0]   stk_wdata,
    input  logic [DW-1:0]   stk_rdata
);

    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] pend;
        logic [NREG-1:0] held;
        logic [AW-1:0]   sp;
        logic [IW-1:0]   tgt;
    } seq_t;

    seq_t q, d;
    logic [IW-1:0] lo_idx, hi_idx;

    function automatic logic [NREG-1:0] bit_of(input logic [IW-1:0] i);
        return {{(NREG-1){1'b0}}, 1'b1} << i;
    endfunction

    lsu_pick #(.N(NREG), .HIGH_FIRST(1'b0)) i_pick_lo (.vec(q.pend), .idx(lo_idx));
    lsu_pick #(.N(NREG), .HIGH_FIRST(1'b1)) i_pick_hi (.vec(q.pend), .idx(hi_idx));

    always_comb begin
        d         = q;
        rf_ridx   = lo_idx;
        rf_we     = 1'b0;
        rf_widx   = q.tgt;
        rf_wdata  = stk_rdata;
        mask_load = 1'b0;
        mask_val  = '0;
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = q.sp;
        stk_wdata = '0;
        case (q.st)
            ST_IDLE: begin
                if (call_i) begin
                    d.pend = mask_i;
                    d.st   = (|mask_i) ? ST_PUSH_REG : ST_PUSH_MASK;
                end else if (ret_i) begin
                    d.st = ST_POP_MASK_REQ;
                end
            end
            ST_PUSH_REG: begin
                stk_we    = 1'b1;
                stk_wdata = rf_rdata;
                d.sp      = q.sp - AW'(1);
                d.pend    = q.pend & ~bit_of(lo_idx);
                if (d.pend == '0) d.st = ST_PUSH_MASK;
            end
            ST_PUSH_MASK: begin
                stk_we    = 1'b1;
                stk_wdata = DW'(mask_i);
                d.sp      = q.sp - AW'(1);
                mask_load = 1'b1;
                mask_val  = '0;
                d.st      = ST_IDLE;
            end
            ST_POP_MASK_REQ: begin
                stk_re   = 1'b1;
                stk_addr = q.sp + AW'(1);
                d.sp     = q.sp + AW'(1);
                d.st     = ST_POP_MASK_CAP;
            end
            ST_POP_MASK_CAP: begin
                d.held = stk_rdata[NREG-1:0];
                d.pend = stk_rdata[NREG-1:0];
                if (stk_rdata[NREG-1:0] == '0) begin
                    mask_load = 1'b1;
                    mask_val  = '0;
                    d.st      = ST_IDLE;
                end else begin
                    d.st = ST_POP_REG_REQ;
                end
            end
            ST_POP_REG_REQ: begin
                stk_re   = 1'b1;
                stk_addr = q.sp + AW'(1);
                d.sp     = q.sp + AW'(1);
                d.tgt    = hi_idx;
                d.pend   = q.pend & ~bit_of(hi_idx);
                d.st     = ST_POP_REG_WR;
            end
            ST_POP_REG_WR: begin
                rf_we = 1'b1;
                if (q.pend == '0) begin
                    mask_load = 1'b1;
                    mask_val  = q.held;
                    d.st      = ST_IDLE;
                end else begin
                    d.st = ST_POP_REG_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.pend <= '0;
            q.held <= '0;
            q.sp   <= SP_INIT;
            q.tgt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

endmodule

// File: rtl/liveset_save_unit.sv
`timescale 1ns/1ps
module liveset_save_unit #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_rel,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_rel,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          call,
    input  logic          ret,
    output logic          busy,
    output logic          stk_we,
    output logic          stk_re,
    output logic [AW-1:0] stk_addr,
    output logic [DW-1:0] stk_wdata,
    input  logic [DW-1:0] stk_rdata
);

    logic            accept;
    logic            seq_rf_we;
    logic [IW-1:0]   seq_rf_widx;
    logic [DW-1:0]   seq_rf_wdata;
    logic [IW-1:0]   seq_rf_ridx;
    logic [DW-1:0]   seq_rf_rdata;
    logic            mask_load;
    logic [NREG-1:0] mask_val;
    logic [NREG-1:0] live_mask;
    logic            rf_we;
    logic [IW-1:0]   rf_widx;
    logic [DW-1:0]   rf_wdata;

    assign accept   = !busy && !call && !ret;
    assign rf_we    = seq_rf_we || (wr_en && accept);
    assign rf_widx  = seq_rf_we ? seq_rf_widx  : wr_idx;
    assign rf_wdata = seq_rf_we ? seq_rf_wdata : wr_data;

    lsu_regfile #(.NREG(NREG), .DW(DW)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_idx  (rd_idx),
        .ra_data (rd_data),
        .rb_idx  (seq_rf_ridx),
        .rb_data (seq_rf_rdata)
    );

    lsu_livemask #(.NREG(NREG)) i_livemask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (wr_en && !wr_rel && accept),
        .set_idx   (wr_idx),
        .clr_a_en  (wr_en && wr_rel && accept),
        .clr_a_idx (wr_idx),
        .clr_b_en  (rd_en && rd_rel && accept),
        .clr_b_idx (rd_idx),
        .load_en   (mask_load),
        .load_val  (mask_val),
        .mask      (live_mask)
    );

    lsu_seq #(.NREG(NREG), .DW(DW), .AW(AW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call),
        .ret_i     (ret),
        .mask_i    (live_mask),
        .rf_rdata  (seq_rf_rdata),
        .rf_ridx   (seq_rf_ridx),
        .rf_we     (seq_rf_we),
        .rf_widx   (seq_rf_widx),
        .rf_wdata  (seq_rf_wdata),
        .mask_load (mask_load),
        .mask_val  (mask_val),
        .busy      (busy),
        .stk_we    (stk_we),
        .stk_re    (stk_re),
        .stk_addr  (stk_addr),
        .stk_wdata (stk_wdata),
        .stk_rdata (stk_rdata)
    );

endmodule

// File: rtl/lsu_checker.sv
`timescale 1ns/1ps
module lsu_checker #(
    parameter int NREG = 16,
    parameter int AW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_rel,
    input logic [IW-1:0]   wr_idx,
    input logic            rd_en,
    input logic            rd_rel,
    input logic [IW-1:0]   rd_idx,
    input logic            call,
    input logic            ret,
    input logic            busy,
    input logic            stk_we,
    input logic            stk_re,
    input logic [AW-1:0]   stk_addr,
    input logic [NREG-1:0] live_mask
);

    localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

    logic [NREG-1:0] wr_bit, rd_bit;
    logic            idle_cmd;

    assign wr_bit   = ONE << wr_idx;
    assign rd_bit   = ONE << rd_idx;
    assign idle_cmd = !busy && !call && !ret;

    assert_single_stack_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re));

    assert_push_addr_descends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - AW'(1)));

    assert_busy_needs_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(call || ret));

    assert_write_marks_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_rel && idle_cmd) |=> ((live_mask & $past(wr_bit)) != '0));

    assert_read_release_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_rel && !wr_en && idle_cmd) |=> ((live_mask & $past(rd_bit)) == '0));

    assert_mask_empty_after_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(stk_we)) |-> (live_mask == '0));

endmodule

bind liveset_save_unit lsu_checker #(.NREG(NREG), .AW(AW)) i_lsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_rel    (wr_rel),
    .wr_idx    (wr_idx),
    .rd_en     (rd_en),
    .rd_rel    (rd_rel),
    .rd_idx    (rd_idx),
    .call      (call),
    .ret       (ret),
    .busy      (busy),
    .stk_we    (stk_we),
    .stk_re    (stk_re),
    .stk_addr  (stk_addr),
    .live_mask (live_mask)
);

// File: tb/test_liveset_save_unit.sv
`timescale 1ns/1ps
module test_liveset_save_unit;

    localparam int OP_WR = 0, OP_WRR = 1, OP_RDR = 2, OP_CHK = 3, OP_CALL = 4, OP_RET = 5;
    localparam int NV = 26;
    // {op, idx, data, expected}: expected is rd_data for reads, word count for call/ret
    localparam logic [70:0] VECS [NV] = '{
        {3'd0, 4'd1,  32'h11,   32'h0},
        {3'd0, 4'd3,  32'h33,   32'h0},
        {3'd0, 4'd10, 32'hAA,   32'h0},
        {3'd4, 4'd0,  32'h0,    32'd4},   // r1,r3,r10 + mask
        {3'd0, 4'd3,  32'h3333, 32'h0},
        {3'd0, 4'd5,  32'h55,   32'h0},
        {3'd4, 4'd0,  32'h0,    32'd3},   // R6: only r3,r5 + mask
        {3'd2, 4'd5,  32'h0,    32'h55},
        {3'd0, 4'd7,  32'h77,   32'h0},
        {3'd2, 4'd7,  32'h0,    32'h77},
        {3'd4, 4'd0,  32'h0,    32'd1},   // R7: empty mask
        {3'd5, 4'd0,  32'h0,    32'd1},
        {3'd0, 4'd5,  32'hDEAD, 32'h0},
        {3'd5, 4'd0,  32'h0,    32'd3},
        {3'd3, 4'd5,  32'h0,    32'h55},
        {3'd3, 4'd3,  32'h0,    32'h3333},
        {3'd0, 4'd3,  32'hBEEF, 32'h0},
        {3'd5, 4'd0,  32'h0,    32'd4},
        {3'd3, 4'd3,  32'h0,    32'h33},
        {3'd3, 4'd1,  32'h0,    32'h11},
        {3'd3, 4'd10, 32'h0,    32'hAA},
        {3'd0, 4'd2,  32'h2,    32'h0},
        {3'd1, 4'd2,  32'h22,   32'h0},
        {3'd3, 4'd2,  32'h0,    32'h22},
        {3'd4, 4'd0,  32'h0,    32'd4},   // r2 released, not saved
        {3'd5, 4'd0,  32'h0,    32'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_rel = 1'b0, rd_en = 1'b0, rd_rel = 1'b0;
    logic [3:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0, rd_data, stk_wdata, stk_rdata;
    logic        call = 1'b0, ret = 1'b0, busy, stk_we, stk_re;
    logic [7:0]  stk_addr;
    logic [31:0] mem [256];
    logic [31:0] push_log [16];
    logic [7:0]  push_addr [16];
    int          push_cnt = 0, pop_cnt = 0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    liveset_save_unit i_liveset_save_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rel(wr_rel), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_en(rd_en), .rd_rel(rd_rel), .rd_idx(rd_idx),
        .rd_data(rd_data), .call(call), .ret(ret), .busy(busy), .stk_we(stk_we),
        .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
    );

    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
        if (stk_re) stk_rdata <= mem[stk_addr];
    end

    always @(negedge clk) begin
        if (stk_we) begin
            if (push_cnt < 16) begin
                push_log[push_cnt]  = stk_wdata;
                push_addr[push_cnt] = stk_addr;
            end
            push_cnt = push_cnt + 1;
        end
        if (stk_re) pop_cnt = pop_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [31:0] data, input logic rel);
        wr_en = 1'b1; wr_rel = rel; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_rel = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [3:0] idx, input logic rel,
                           input logic [31:0] exp);
        rd_idx = idx; rd_en = 1'b1; rd_rel = rel;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0; rd_rel = 1'b0;
    endtask

    task automatic do_call(input string req, input int exp);
        push_cnt = 0;
        call = 1'b1;
        @(negedge clk);
        call = 1'b0;
        wait_idle();
        check(req, 32'(push_cnt), 32'(exp));
    endtask

    task automatic do_ret(input string req, input int exp);
        pop_cnt = 0;
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
        wait_idle();
        check(req, 32'(pop_cnt), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=busy expected=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports, then an empty-mask call
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 stk_we", 32'(stk_we), 32'd0);
        check("R1 stk_re", 32'(stk_re), 32'd0);
        do_call("R7 call after reset", 1);
        check("R1 pushed mask word", push_log[0], 32'h0);
        check("R5 first push address", 32'(push_addr[0]), 32'hFF);
        do_ret("R8 pop after reset", 1);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  op;
            logic [3:0]  idx;
            logic [31:0] data, exp;
            {op, idx, data, exp} = VECS[v];
            case (int'(op))
                OP_WR:   do_write(idx, data, 1'b0);
                OP_WRR:  do_write(idx, data, 1'b1);
                OP_RDR:  do_read("R3 read release", idx, 1'b1, exp);
                OP_CHK:  do_read("R8 restored value", idx, 1'b0, exp);
                OP_CALL: do_call("R5 push count", int'(exp));
                default: do_ret("R8 pop count", int'(exp));
            endcase
        end

        // R2: plain write readback
        do_read("R2 write readback", 4'd10, 1'b0, 32'hAA);

        // R5: order of pushes and descending addresses; live set {1,3,10}
        do_call("R5 ordered save", 4);
        check("R5 push0", push_log[0], 32'h11);
        check("R5 push1", push_log[1], 32'h33);
        check("R5 push2", push_log[2], 32'hAA);
        check("R5 mask word", push_log[3], 32'h0000040A);
        check("R5 addr step", 32'(push_addr[3]), 32'(push_addr[0] - 8'd3));

        // R4: set and release on r4 in one cycle, set wins; R6: earlier regs not resaved
        rd_idx = 4'd4; rd_en = 1'b1; rd_rel = 1'b1;
        do_write(4'd4, 32'h44, 1'b0);
        rd_en = 1'b0; rd_rel = 1'b0;
        do_call("R4 set wins count", 2);
        check("R4 saved r4", push_log[0], 32'h44);
        check("R6 mask word only r4", push_log[1], 32'h10);

        // R9: register command in call cycle and call/write during busy are ignored
        do_write(4'd6, 32'h66, 1'b0);
        push_cnt = 0;
        call = 1'b1; wr_en = 1'b1; wr_idx = 4'd11; wr_data = 32'hBB;
        @(negedge clk);
        call = 1'b1; wr_idx = 4'd9; wr_data = 32'h99;
        @(negedge clk);
        call = 1'b0; wr_en = 1'b0;
        wait_idle();
        check("R9 pushes with busy call", 32'(push_cnt), 32'd2);
        do_read("R9 write in call cycle ignored", 4'd11, 1'b0, 32'h0);
        do_read("R9 write while busy ignored", 4'd9, 1'b0, 32'h0);
        do_call("R9 mask unchanged by ignored writes", 1);

        // R10: restore through stack read latency
        do_write(4'd6, 32'h1, 1'b0);
        do_ret("R8 empty frame", 1);
        do_ret("R10 frame r6", 2);
        do_read("R10 r6 restored", 4'd6, 1'b0, 32'h66);
        do_ret("R10 frame r4", 2);
        do_ret("R8 frame r1 r3 r10", 4);
        do_read("R8 r3 after unwind", 4'd3, 1'b0, 32'h33);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule